// File: doc/BRIEF.md
# SDRAM Open-Row Page Table

This block remembers, for every bank of every chip select, whether a row is currently open and which row it is. A memory scheduler presents a lookup (chip select, bank, row) and receives a classification one clock later. A page hit means the access can go straight to a read or write. A page empty means the bank must be activated first. A page conflict means the bank must be precharged and then activated.

The command path reports the row commands it issues: activate, single-bank precharge and precharge of all banks of one chip select. A separate close-all input is raised whenever every page in the memory must be considered closed, for example before a refresh or on entry into self-refresh. With the default parameters the table holds sixteen independent entries, four chip selects by four banks, each with a 13-bit row number.

Top module: `sdram_page_table`

## Requirements
- R1: While reset is asserted and in the cycle after its release, res_valid is 0. After reset every one of the 16 entries is closed, so the first lookup of any entry returns empty.
- R2: res_valid equals the lkp_valid sampled at the previous rising clock edge. res_class then holds the classification of that lookup.
- R3: A lookup of an entry that holds no open row returns empty, encoded 2'b01.
- R4: A lookup of an open entry whose stored row equals lkp_row returns hit, encoded 2'b00.
- R5: A lookup of an open entry whose stored row differs from lkp_row returns conflict, encoded 2'b10.
- R6: An activate opens the entry at {cmd_cs, cmd_bank} with cmd_row. No other entry changes.
- R7: A single-bank precharge closes only the entry at {cmd_cs, cmd_bank}.
- R8: A precharge-all closes the four bank entries of cmd_cs. The entries of the other chip selects keep their state.
- R9: close_all closes all 16 entries. It overrides any row command issued in the same cycle.
- R10: When a lookup and a row command fall in the same cycle, the lookup is classified against the table as it is after that command.
- R11: At most one of cmd_act, cmd_pre and cmd_pre_all is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lkp_valid | input | 1 | A lookup is presented this cycle |
| lkp_cs | input | 2 | Chip select of the lookup |
| lkp_bank | input | 2 | Bank of the lookup |
| lkp_row | input | 13 | Row of the lookup |
| cmd_act | input | 1 | Activate issued to cmd_cs / cmd_bank |
| cmd_pre | input | 1 | Precharge issued to cmd_cs / cmd_bank |
| cmd_pre_all | input | 1 | Precharge of all banks of cmd_cs |
| cmd_cs | input | 2 | Chip select of the row command |
| cmd_bank | input | 2 | Bank of the row command |
| cmd_row | input | 13 | Row opened by an activate |
| close_all | input | 1 | Close every entry (refresh, self-refresh entry) |
| res_valid | output | 1 | Classification result is valid |
| res_class | output | 2 | 00 hit, 01 empty, 10 conflict |

## Verification
The assertions assume that the command path issues at most one row command per cycle, as R11 requires. The one-per-cycle checks on the decoded entry strobes rely on that assumption. They also assume that close_all may coincide with any command and wins over it. The stimulus therefore picks a single command, or none, for each cycle and adds close_all only now and then on top of it. Lookups are drawn from a small pool of rows so that hits, empties and conflicts all occur often. Some lookups are deliberately aimed at the entry being updated in the same cycle.

// File: rtl/sdpt_pkg.sv
package sdpt_pkg;

  typedef enum logic [1:0] {
    PG_HIT      = 2'b00,
    PG_EMPTY    = 2'b01,
    PG_CONFLICT = 2'b10
  } pg_class_e;

  // Classification of one access against one entry.
  function automatic pg_class_e pg_classify(input logic is_open, input logic same_row);
    if (!is_open)     return PG_EMPTY;
    else if (same_row) return PG_HIT;
    else              return PG_CONFLICT;
  endfunction

endpackage

// File: rtl/sdpt_entry.sv
module sdpt_entry #(
  parameter int ROW_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             clr_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             vld_o,
  output logic             vld_nx_o,
  output logic [ROW_W-1:0] row_nx_o
);

  logic             vld_q;
  logic [ROW_W-1:0] row_q;

  // Next state: a close has priority over an open.
  always_comb begin
    vld_nx_o = vld_q;
    row_nx_o = row_q;
    if (clr_i) begin
      vld_nx_o = 1'b0;
    end else if (set_i) begin
      vld_nx_o = 1'b1;
      row_nx_o = row_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      row_q <= '0;
    end else begin
      vld_q <= vld_nx_o;
      row_q <= row_nx_o;
    end
  end

  assign vld_o = vld_q;

  a_r6_open_stores_row: assert property (@(posedge clk) disable iff (!rst_n)
    set_i && !clr_i |=> vld_q && (row_q == $past(row_i)));

  a_r7_close_clears: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> !vld_q);

  a_r6_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !set_i && !clr_i |=> $stable(vld_q) && $stable(row_q));

endmodule

// File: rtl/sdpt_decode.sv
module sdpt_decode #(
  parameter int CS_W   = 2,
  parameter int BANK_W = 2,
  localparam int NUM_BANKS = 1 << BANK_W,
  localparam int NUM_ENT   = 1 << (CS_W + BANK_W)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_act,
  input  logic               cmd_pre,
  input  logic               cmd_pre_all,
  input  logic [CS_W-1:0]    cmd_cs,
  input  logic [BANK_W-1:0]  cmd_bank,
  input  logic               close_all,
  output logic [NUM_ENT-1:0] set_vec,
  output logic [NUM_ENT-1:0] clr_vec
);

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_ent
    localparam logic [CS_W-1:0]   E_CS   = CS_W'(e >> BANK_W);
    localparam logic [BANK_W-1:0] E_BANK = BANK_W'(e % NUM_BANKS);
    logic cs_match;
    logic bank_match;
    assign cs_match   = (cmd_cs == E_CS);
    assign bank_match = cs_match && (cmd_bank == E_BANK);
    assign set_vec[e] = cmd_act && bank_match;
    assign clr_vec[e] = close_all || (cmd_pre && bank_match) || (cmd_pre_all && cs_match);
  end

  a_r11_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_act, cmd_pre, cmd_pre_all}));

  a_r6_single_open: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_act |-> $countones(set_vec) == 1);

  a_r7_single_close: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pre && !close_all |-> $countones(clr_vec) == 1);

  a_r8_cs_close: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pre_all && !close_all |-> $countones(clr_vec) == NUM_BANKS);

  a_r9_close_every: assert property (@(posedge clk) disable iff (!rst_n)
    close_all |-> $countones(clr_vec) == NUM_ENT);

endmodule

// File: rtl/sdpt_lookup.sv
module sdpt_lookup
  import sdpt_pkg::*;
#(
  parameter int CS_W   = 2,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13,
  localparam int NUM_ENT = 1 << (CS_W + BANK_W)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          lkp_valid,
  input  logic [CS_W-1:0]               lkp_cs,
  input  logic [BANK_W-1:0]             lkp_bank,
  input  logic [ROW_W-1:0]              lkp_row,
  input  logic [NUM_ENT-1:0]            nx_vld,
  input  logic [NUM_ENT-1:0][ROW_W-1:0] nx_row,
  output logic                          res_valid,
  output pg_class_e                     res_class
);

  logic [CS_W+BANK_W-1:0] sel_idx;
  logic                   sel_open;
  logic                   sel_same;
  pg_class_e              sel_class;

  // Classify against the post-update table state (R10).
  assign sel_idx   = {lkp_cs, lkp_bank};
  assign sel_open  = nx_vld[sel_idx];
  assign sel_same  = (nx_row[sel_idx] == lkp_row);
  assign sel_class = pg_classify(sel_open, sel_same);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_class <= PG_EMPTY;
    end else begin
      res_valid <= lkp_valid;
      if (lkp_valid) res_class <= sel_class;
    end
  end

  a_r2_valid_on: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_valid |=> res_valid);

  a_r2_valid_off: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_valid |=> !res_valid);

  a_r3_closed_is_empty: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_valid && !sel_open |=> res_class == PG_EMPTY);

  a_r4_same_is_hit: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_valid && sel_open && sel_same |=> res_class == PG_HIT);

  a_r5_other_is_conflict: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_valid && sel_open && !sel_same |=> res_class == PG_CONFLICT);

endmodule

// File: rtl/sdram_page_table.sv
module sdram_page_table
  import sdpt_pkg::*;
#(
  parameter int CS_W   = 2,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkp_valid,
  input  logic [CS_W-1:0]   lkp_cs,
  input  logic [BANK_W-1:0] lkp_bank,
  input  logic [ROW_W-1:0]  lkp_row,
  input  logic              cmd_act,
  input  logic              cmd_pre,
  input  logic              cmd_pre_all,
  input  logic [CS_W-1:0]   cmd_cs,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [ROW_W-1:0]  cmd_row,
  input  logic              close_all,
  output logic              res_valid,
  output logic [1:0]        res_class
);

  localparam int NUM_ENT = 1 << (CS_W + BANK_W);

  logic [NUM_ENT-1:0]            set_vec;
  logic [NUM_ENT-1:0]            clr_vec;
  logic [NUM_ENT-1:0]            vld_vec;
  logic [NUM_ENT-1:0]            nx_vld;
  logic [NUM_ENT-1:0][ROW_W-1:0] nx_row;
  pg_class_e                     res_class_e;

  sdpt_decode #(.CS_W(CS_W), .BANK_W(BANK_W)) u_decode (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_act     (cmd_act),
    .cmd_pre     (cmd_pre),
    .cmd_pre_all (cmd_pre_all),
    .cmd_cs      (cmd_cs),
    .cmd_bank    (cmd_bank),
    .close_all   (close_all),
    .set_vec     (set_vec),
    .clr_vec     (clr_vec)
  );

  for (genvar e = 0; e < NUM_ENT; e++) begin : g_tab
    sdpt_entry #(.ROW_W(ROW_W)) u_entry (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_i    (set_vec[e]),
      .clr_i    (clr_vec[e]),
      .row_i    (cmd_row),
      .vld_o    (vld_vec[e]),
      .vld_nx_o (nx_vld[e]),
      .row_nx_o (nx_row[e])
    );
  end

  sdpt_lookup #(.CS_W(CS_W), .BANK_W(BANK_W), .ROW_W(ROW_W)) u_lookup (
    .clk       (clk),
    .rst_n     (rst_n),
    .lkp_valid (lkp_valid),
    .lkp_cs    (lkp_cs),
    .lkp_bank  (lkp_bank),
    .lkp_row   (lkp_row),
    .nx_vld    (nx_vld),
    .nx_row    (nx_row),
    .res_valid (res_valid),
    .res_class (res_class_e)
  );

  assign res_class = res_class_e;

  a_r9_all_closed: assert property (@(posedge clk) disable iff (!rst_n)
    close_all |=> vld_vec == '0);

  a_r1_never_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_class != 2'b11);

endmodule

// File: tb/test_sdram_page_table.sv
module test_sdram_page_table;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lkp_valid = 1'b0;
  logic [1:0]  lkp_cs = '0;
  logic [1:0]  lkp_bank = '0;
  logic [12:0] lkp_row = '0;
  logic        cmd_act = 1'b0;
  logic        cmd_pre = 1'b0;
  logic        cmd_pre_all = 1'b0;
  logic [1:0]  cmd_cs = '0;
  logic [1:0]  cmd_bank = '0;
  logic [12:0] cmd_row = '0;
  logic        close_all = 1'b0;
  logic        res_valid;
  logic [1:0]  res_class;

  int    total = 0;
  int    bad = 0;
  bit    done = 0;
  bit    checking = 0;
  string phase = "R1 reset";

  // Reference model state.
  bit    m_open [16];
  int    m_row  [16];
  bit    exp_vld = 0;
  int    exp_cls = 1;

  always #(CLK_P/2) clk = ~clk;

  sdram_page_table i_sdram_page_table (
    .clk(clk), .rst_n(rst_n),
    .lkp_valid(lkp_valid), .lkp_cs(lkp_cs), .lkp_bank(lkp_bank), .lkp_row(lkp_row),
    .cmd_act(cmd_act), .cmd_pre(cmd_pre), .cmd_pre_all(cmd_pre_all),
    .cmd_cs(cmd_cs), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .close_all(close_all), .res_valid(res_valid), .res_class(res_class)
  );

  // Model: apply the command first, then classify the lookup (R10).
  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_open[i]) begin m_open[i] = 0; m_row[i] = 0; end
      exp_vld = 0;
    end else begin
      if (close_all) begin
        foreach (m_open[i]) m_open[i] = 0;
      end else if (cmd_act) begin
        m_open[cmd_cs*4 + cmd_bank] = 1;
        m_row[cmd_cs*4 + cmd_bank]  = cmd_row;
      end else if (cmd_pre) begin
        m_open[cmd_cs*4 + cmd_bank] = 0;
      end else if (cmd_pre_all) begin
        for (int b = 0; b < 4; b++) m_open[cmd_cs*4 + b] = 0;
      end
      exp_vld = lkp_valid;
      if (lkp_valid) begin
        if (!m_open[lkp_cs*4 + lkp_bank])               exp_cls = 1;
        else if (m_row[lkp_cs*4 + lkp_bank] == lkp_row) exp_cls = 0;
        else                                            exp_cls = 2;
      end
    end
  end

  function automatic string cls_tag(int c);
    if (c == 0) return "R4";
    if (c == 1) return "R3";
    return "R5";
  endfunction

  always @(negedge clk) begin
    if (checking) begin
      total++;
      if (res_valid !== exp_vld) begin
        bad++;
        $display("FAIL R2 [%s] res_valid actual=%0b expected=%0b", phase, res_valid, exp_vld);
      end else if (exp_vld) begin
        total++;
        if (res_class !== 2'(exp_cls)) begin
          bad++;
          $display("FAIL %s [%s] res_class actual=%0d expected=%0d",
                   cls_tag(exp_cls), phase, res_class, exp_cls);
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
    lkp_valid = 0; cmd_act = 0; cmd_pre = 0; cmd_pre_all = 0; close_all = 0;
  endtask

  task automatic look(int cs, int b, int row);
    lkp_valid = 1; lkp_cs = 2'(cs); lkp_bank = 2'(b); lkp_row = 13'(row);
  endtask

  task automatic act(int cs, int b, int row);
    cmd_act = 1; cmd_cs = 2'(cs); cmd_bank = 2'(b); cmd_row = 13'(row);
  endtask

  task automatic pre(int cs, int b);
    cmd_pre = 1; cmd_cs = 2'(cs); cmd_bank = 2'(b);
  endtask

  task automatic pre_all(int cs);
    cmd_pre_all = 1; cmd_cs = 2'(cs);
  endtask

  task automatic scan_all(int row);
    for (int e = 0; e < 16; e++) begin look(e / 4, e % 4, row); tick(); end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs idle during reset
    total++;
    if (res_valid !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset res_valid actual=%0b expected=0", res_valid);
    end
    rst_n = 1;
    checking = 1;
    tick();
    phase = "R1 all entries closed after reset";
    scan_all(0);

    phase = "R6 activate opens one entry";
    act(1, 2, 100); tick();
    look(1, 2, 100); tick();
    look(1, 1, 100); tick();
    look(0, 2, 100); tick();
    phase = "R5 conflict on other row";
    look(1, 2, 101); tick();
    look(1, 2, 8191); tick();

    phase = "R10 update and lookup same cycle";
    act(0, 0, 5); look(0, 0, 5); tick();
    act(0, 0, 6); look(0, 0, 5); tick();
    pre(0, 0); look(0, 0, 6); tick();

    phase = "R7 precharge closes one entry";
    act(1, 3, 100); tick();
    pre(1, 2); tick();
    look(1, 2, 100); tick();
    look(1, 3, 100); tick();

    phase = "R8 precharge-all of one chip select";
    for (int e = 0; e < 16; e++) begin act(e / 4, e % 4, 7); tick(); end
    pre_all(2); tick();
    scan_all(7);

    phase = "R9 close_all wins over activate";
    close_all = 1; act(3, 3, 7); tick();
    scan_all(7);

    phase = "R2 R11 random single commands";
    for (int n = 0; n < 4000; n++) begin
      int r;
      int rows [4] = '{0, 1, 2, 8191};
      r = int'($urandom_range(0, 15));
      if (r < 5)       act(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), rows[$urandom_range(0, 3)]);
      else if (r < 7)  pre(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)));
      else if (r == 7) pre_all(int'($urandom_range(0, 3)));
      if ($urandom_range(0, 31) == 0) close_all = 1;
      if ($urandom_range(0, 9) < 7)
        look(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), rows[$urandom_range(0, 3)]);
      tick();
    end
    tick();
    checking = 0;
    done = 1;
    summary();
    $finish;
  end

endmodule